// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps wall-clock time as packed-BCD counters: seconds, minutes, hours, day of month, month (all 8 bits) and a full four-digit year (16 bits, 0000 to 9999). A sub-second pulse, `sub_tick`, feeds an internal divider. Every `DIV` accepted pulses make one second step. That step ripples through the calendar with month lengths and the Gregorian leap rule. A single-cycle register port lets a host write any register and read any register combinationally.

A control state machine governs counting and loading. It has three states. **HALT** is the reset state: counters are frozen and loads are refused. **ARMED** is stopped with the divider cleared, and it is the only state that accepts counter loads. **RUN** is the counting state. Writes to the command register cause the transitions. *Go* is a write with bit 0 set, taken from any state to RUN. *Arm* is a write with bit 0 clear and bit 1 set, taken from any state to ARMED. *Stop* is a write with both bits clear, taken from RUN to HALT. The same write leaves HALT and ARMED where they are.

Every second step sets a carry flag. The host clears the flag, reads all counters, and then checks the flag again. If the flag is set, a carry happened during the read and the host reads again.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset, sec/min/hour read 00, day and month read 01, year reads 2000, and both control registers read 0x0000. `carry_irq`, `rtc_enabled` and `osc_en` are 0, and the state is HALT.
- R2: In RUN, the seconds advance by one on every DIV-th accepted `sub_tick` (DIV=4 by default). In HALT and ARMED the counters never change on ticks.
- R3: Seconds and minutes wrap from 59 to 00 and carry onward. Hours wrap from 23 to 00 and carry into the day. All digits count in BCD, with a nibble carry after 9.
- R4: The day wraps to 01 after the last day of the current month (30 for months 04, 06, 09 and 11; 31 for the other months except February). The month wraps from 12 to 01 and increments the year.
- R5: February has 29 days when the year is a multiple of 4, except for century years that are not multiples of 400. Otherwise it has 28.
- R6: The year wraps from 9999 to 0000.
- R7: Status register (address 0) bit 7 is the carry flag. Every second step sets it. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R8: Counter registers (address 2 sec, 3 min, 4 hour, 5 day, 6 month, 7 year; data in `wdata[7:0]`, year in `wdata[15:0]`) load only in ARMED. Writes to them in HALT or RUN are ignored.
- R9: Command register (address 1) bit 1 clears the divider on the cycle of the write and always reads back as 0. Bit 0 reads 1 only in RUN.
- R10: A `sub_tick` on the same cycle as any host write is discarded and does not advance the divider.
- R11: Status register bit 4 enables the carry interrupt, bit 3 enables the alarm and drives `rtc_enabled`, and bit 0 is a stored alarm flag. `carry_irq` is high when the carry flag and bit 4 are both 1.
- R12: Command register bit 3 is the oscillator-select bit. It reads back and drives `osc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | Sub-second pulse, one cycle wide |
| wr_en | input | 1 | Host write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| carry_irq | output | 1 | Carry interrupt request |
| rtc_enabled | output | 1 | Alarm interrupt enable, used as the enabled indication |
| osc_en | output | 1 | Oscillator-select control |

## Verification
Some properties are checked on every cycle. Counters stay still outside RUN unless the host writes. A second step always leaves the carry flag set. No step occurs on a host-write cycle. A seconds write in RUN has no effect. Seconds at 59 wrap to 00.

Other behaviour shows only in the bench scenarios. These cover the month-length and leap-year calendar results, the 9999 wrap, the divider restart after the clear bit, the read-back of control bits, and loading through the stop/arm/go sequence. Randomised dates near the ends of minutes, hours, days and months are compared against a binary calendar model.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } rtc_state_e;

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_CMD  = 3'd1;
    localparam logic [2:0] A_SEC  = 3'd2;
    localparam logic [2:0] A_MIN  = 3'd3;
    localparam logic [2:0] A_HOUR = 3'd4;
    localparam logic [2:0] A_DAY  = 3'd5;
    localparam logic [2:0] A_MON  = 3'd6;
    localparam logic [2:0] A_YEAR = 3'd7;

    localparam int STAT_CF  = 7;
    localparam int STAT_CIE = 4;
    localparam int STAT_AIE = 3;
    localparam int STAT_AF  = 0;
    localparam int CMD_GO   = 0;
    localparam int CMD_CLR  = 1;
    localparam int CMD_OSC  = 3;

    function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [15:0] bcd_inc16(input logic [15:0] v);
        logic [15:0] r;
        logic        c;
        r = v;
        c = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (c) begin
                if (v[4*i +: 4] >= 4'd9) r[4*i +: 4] = 4'd0;
                else begin
                    r[4*i +: 4] = v[4*i +: 4] + 4'd1;
                    c = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // two-digit BCD value divisible by four
    function automatic logic bcd_div4(input logic [7:0] v);
        if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
        return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
    endfunction

    function automatic logic bcd_leap(input logic [15:0] yr);
        if (yr[7:0] != 8'h00) return bcd_div4(yr[7:0]);
        return bcd_div4(yr[15:8]);
    endfunction

    function automatic logic [7:0] bcd_month_len(input logic [7:0] mon, input logic [15:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_divider.sv
`timescale 1ns/1ps
module rtc_divider #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ok,
    input  logic clr,
    output logic sec_pulse
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign sec_pulse = tick_ok && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (clr)     cnt <= '0;
        else if (tick_ok) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_ctrl.sv
`timescale 1ns/1ps
module rtc_ctrl
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wbyte,
    input  logic       sec_pulse,
    output rtc_state_e state,
    output logic       tick_ok,
    output logic       div_clr,
    output logic       ld_en,
    output logic       cf,
    output logic       cie,
    output logic       aie,
    output logic       af,
    output logic       osc
);
    rtc_state_e nxt;
    logic       cmd_wr;
    logic       stat_wr;
    logic       unused_bits;

    assign cmd_wr      = wr_en && (addr == A_CMD);
    assign stat_wr     = wr_en && (addr == A_STAT);
    assign unused_bits = ^{wbyte[6:5], wbyte[2]};

    // transitions: go, arm, stop
    always_comb begin
        nxt = state;
        if (cmd_wr) begin
            if (wbyte[CMD_GO])       nxt = ST_RUN;
            else if (wbyte[CMD_CLR]) nxt = ST_ARMED;
            else if (state == ST_RUN) nxt = ST_HALT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HALT;
        else        state <= nxt;
    end

    always_comb begin
        tick_ok = 1'b0;
        ld_en   = 1'b0;
        div_clr = cmd_wr && wbyte[CMD_CLR];
        unique case (state)
            ST_HALT:  ;
            ST_ARMED: ld_en   = wr_en && (addr >= A_SEC);
            ST_RUN:   tick_ok = sub_tick && !wr_en;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cf  <= 1'b0;
            cie <= 1'b0;
            aie <= 1'b0;
            af  <= 1'b0;
            osc <= 1'b0;
        end else begin
            if (stat_wr) begin
                cie <= wbyte[STAT_CIE];
                aie <= wbyte[STAT_AIE];
                af  <= wbyte[STAT_AF];
                if (!wbyte[STAT_CF]) cf <= 1'b0;
            end
            if (sec_pulse) cf  <= 1'b1;
            if (cmd_wr)    osc <= wbyte[CMD_OSC];
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    input  logic        ld_en,
    input  logic [2:0]  ld_addr,
    input  logic [15:0] ld_data,
    output logic [7:0]  sec_q,
    output logic [7:0]  min_q,
    output logic [7:0]  hr_q,
    output logic [7:0]  day_q,
    output logic [7:0]  mon_q,
    output logic [15:0] yr_q
);
    logic sec_w, min_w, hr_w, day_w, mon_w;

    assign sec_w = sec_q >= 8'h59;
    assign min_w = min_q >= 8'h59;
    assign hr_w  = hr_q  >= 8'h23;
    assign day_w = day_q >= bcd_month_len(mon_q, yr_q);
    assign mon_w = mon_q >= 8'h12;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= 8'h00;
            min_q <= 8'h00;
            hr_q  <= 8'h00;
            day_q <= 8'h01;
            mon_q <= 8'h01;
            yr_q  <= 16'h2000;
        end else if (ld_en) begin
            case (ld_addr)
                A_SEC:   sec_q <= ld_data[7:0];
                A_MIN:   min_q <= ld_data[7:0];
                A_HOUR:  hr_q  <= ld_data[7:0];
                A_DAY:   day_q <= ld_data[7:0];
                A_MON:   mon_q <= ld_data[7:0];
                A_YEAR:  yr_q  <= ld_data;
                default: ;
            endcase
        end else if (step) begin
            sec_q <= sec_w ? 8'h00 : bcd_inc8(sec_q);
            if (sec_w) begin
                min_q <= min_w ? 8'h00 : bcd_inc8(min_q);
                if (min_w) begin
                    hr_q <= hr_w ? 8'h00 : bcd_inc8(hr_q);
                    if (hr_w) begin
                        day_q <= day_w ? 8'h01 : bcd_inc8(day_q);
                        if (day_w) begin
                            mon_q <= mon_w ? 8'h01 : bcd_inc8(mon_q);
                            if (mon_w) yr_q <= bcd_inc16(yr_q);
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bcd_calendar_rtc.sv
`timescale 1ns/1ps
module bcd_calendar_rtc
    import rtc_cal_pkg::*;
#(
    parameter int DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sub_tick,
    input  logic        wr_en,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        carry_irq,
    output logic        rtc_enabled,
    output logic        osc_en
);
    rtc_state_e  state;
    logic        tick_ok, div_clr, ld_en, sec_pulse;
    logic        cf, cie, aie, af, osc;
    logic [7:0]  sec_q, min_q, hr_q, day_q, mon_q;
    logic [15:0] yr_q;

    rtc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .wr_en(wr_en),
        .addr(addr), .wbyte(wdata[7:0]), .sec_pulse(sec_pulse),
        .state(state), .tick_ok(tick_ok), .div_clr(div_clr), .ld_en(ld_en),
        .cf(cf), .cie(cie), .aie(aie), .af(af), .osc(osc)
    );

    rtc_divider #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_ok(tick_ok), .clr(div_clr),
        .sec_pulse(sec_pulse)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .step(sec_pulse), .ld_en(ld_en),
        .ld_addr(addr), .ld_data(wdata),
        .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .day_q(day_q),
        .mon_q(mon_q), .yr_q(yr_q)
    );

    always_comb begin
        case (addr)
            A_STAT:  rdata = {8'h00, cf, 2'b00, cie, aie, 2'b00, af};
            A_CMD:   rdata = {12'h000, osc, 2'b00, state == ST_RUN};
            A_SEC:   rdata = {8'h00, sec_q};
            A_MIN:   rdata = {8'h00, min_q};
            A_HOUR:  rdata = {8'h00, hr_q};
            A_DAY:   rdata = {8'h00, day_q};
            A_MON:   rdata = {8'h00, mon_q};
            default: rdata = yr_q;
        endcase
    end

    assign carry_irq   = cf && cie;
    assign rtc_enabled = aie;
    assign osc_en      = osc;
endmodule

// File: rtl/rtc_cal_chk.sv
`timescale 1ns/1ps
module rtc_cal_chk
    import rtc_cal_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [2:0]  addr,
    input rtc_state_e  state,
    input logic        sec_pulse,
    input logic [7:0]  sec_q,
    input logic [15:0] yr_q,
    input logic        cf
);
    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && !wr_en) |=> ($stable(sec_q) && $stable(yr_q)));

    // R7
    carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> cf);

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !sec_pulse);

    // R8
    run_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == ST_RUN && addr == A_SEC) |=> $stable(sec_q));

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && sec_q == 8'h59) |=> (sec_q == 8'h00));
endmodule

bind bcd_calendar_rtc rtc_cal_chk u_chk (.*);

// File: tb/tb_bcd_calendar_rtc.sv
`timescale 1ns/1ps
module tb_bcd_calendar_rtc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sub_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        carry_irq, rtc_enabled, osc_en;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    int ms, mm, mh, md, mo, my;

    bcd_calendar_rtc dut (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .carry_irq(carry_irq),
        .rtc_enabled(rtc_enabled), .osc_en(osc_en)
    );

    always #10 clk = ~clk;

    function automatic int dim(input int m, input int y);
        bit leap;
        leap = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (m == 2) return leap ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [15:0] to_bcd(input int v);
        return 16'(((v / 1000) % 10) << 12 | ((v / 100) % 10) << 8 | ((v / 10) % 10) << 4 | (v % 10));
    endfunction

    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            ms++;
            if (ms == 60) begin
                ms = 0; mm++;
                if (mm == 60) begin
                    mm = 0; mh++;
                    if (mh == 24) begin
                        mh = 0; md++;
                        if (md > dim(mo, my)) begin
                            md = 1; mo++;
                            if (mo == 13) begin
                                mo = 1; my++;
                                if (my == 10000) my = 0;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; sub_tick = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; sub_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sub_tick = 1'b1;
            @(negedge clk); sub_tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic check_time(input string req);
        logic [15:0] v;
        rd(3'd2, v); chk(req, v, to_bcd(ms));
        rd(3'd3, v); chk(req, v, to_bcd(mm));
        rd(3'd4, v); chk(req, v, to_bcd(mh));
        rd(3'd5, v); chk(req, v, to_bcd(md));
        rd(3'd6, v); chk(req, v, to_bcd(mo));
        rd(3'd7, v); chk(req, v, to_bcd(my));
    endtask

    // stop+arm, load every counter, then go
    task automatic load(input int y, input int mo_i, input int d, input int h, input int mi, input int s);
        wr(3'd1, 16'h0002);
        wr(3'd2, to_bcd(s));
        wr(3'd3, to_bcd(mi));
        wr(3'd4, to_bcd(h));
        wr(3'd5, to_bcd(d));
        wr(3'd6, to_bcd(mo_i));
        wr(3'd7, to_bcd(y));
        wr(3'd1, 16'h0001);
        my = y; mo = mo_i; md = d; mh = h; mm = mi; ms = s;
    endtask

    task automatic roll(input string req, input int y, input int mo_i, input int d);
        load(y, mo_i, d, 23, 59, 59);
        ticks(4); adv(1);
        check_time(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240229));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        ms = 0; mm = 0; mh = 0; md = 1; mo = 1; my = 2000;
        check_time("R1");
        rd(3'd0, v); chk("R1 stat", v, 16'h0000);
        rd(3'd1, v); chk("R1 cmd", v, 16'h0000);
        chk("R1 outs", {13'h0, carry_irq, rtc_enabled, osc_en}, 16'h0);

        // R2 no counting while halted; R8 load in HALT ignored
        ticks(8);
        wr(3'd2, 16'h0030);
        check_time("R2 R8 halt");

        // R8 load in ARMED then run, R2 divider
        load(2023, 6, 15, 10, 20, 30);
        check_time("R8 load");
        ticks(4); adv(1); check_time("R2 one second");
        ticks(3); check_time("R2 partial");
        ticks(1); adv(1); check_time("R2 complete");

        // R8 write in RUN ignored
        wr(3'd2, 16'h0000);
        check_time("R8 run write");

        // R10 write beats tick
        ticks(3);
        wr_tick(3'd0, 16'h0000);
        check_time("R10 discarded");
        ticks(1); adv(1); check_time("R10 resumed");

        // R9 divider clear
        ticks(3);
        wr(3'd1, 16'h0003);
        rd(3'd1, v); chk("R9 readback", v, 16'h0001);
        ticks(3); check_time("R9 cleared");
        ticks(1); adv(1); check_time("R9 restart");

        // R7 carry flag
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R7 cleared", v, 16'h0000);
        ticks(4); adv(1);
        rd(3'd0, v); chk("R7 set", v, 16'h0080);
        wr(3'd0, 16'h0080);
        rd(3'd0, v); chk("R7 write one keeps", v, 16'h0080);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R7 write zero clears", v, 16'h0000);

        // R11 enables and alarm flag
        wr(3'd0, 16'h0019);
        rd(3'd0, v); chk("R11 stat", v, 16'h0019);
        chk("R11 enabled", {15'h0, rtc_enabled}, 16'h1);
        chk("R11 irq idle", {15'h0, carry_irq}, 16'h0);
        ticks(4); adv(1);
        chk("R11 irq", {15'h0, carry_irq}, 16'h1);
        rd(3'd0, v); chk("R11 stat cf", v, 16'h0099);
        wr(3'd0, 16'h0008);
        chk("R11 irq off", {14'h0, carry_irq, rtc_enabled}, 16'h1);

        // R12 oscillator bit
        wr(3'd1, 16'h0009);
        chk("R12 osc on", {15'h0, osc_en}, 16'h1);
        rd(3'd1, v); chk("R12 readback", v, 16'h0009);
        wr(3'd1, 16'h0001);
        chk("R12 osc off", {15'h0, osc_en}, 16'h0);
        check_time("R2 still");

        // stop from RUN: HALT freezes and refuses loads
        wr(3'd1, 16'h0000);
        ticks(8);
        wr(3'd2, 16'h0011);
        check_time("R2 R8 stopped");
        rd(3'd1, v); chk("R9 halt readback", v, 16'h0000);
        wr(3'd1, 16'h0001);

        // directed rollovers
        load(2023, 6, 15, 12, 59, 59); ticks(4); adv(1); check_time("R3 minute hour");
        roll("R3 day", 2023, 6, 15);
        roll("R4 april", 2023, 4, 30);
        roll("R4 january", 2023, 1, 31);
        roll("R4 year", 1999, 12, 31);
        roll("R5 2024 feb28", 2024, 2, 28);
        roll("R5 2024 feb29", 2024, 2, 29);
        roll("R5 2100", 2100, 2, 28);
        roll("R5 2000", 2000, 2, 28);
        roll("R5 2023", 2023, 2, 28);
        roll("R6 wrap", 9999, 12, 31);

        // constrained random near rollover boundaries
        for (int it = 0; it < 24; it++) begin
            int y, m, d, n;
            y = 1896 + int'($urandom % 520);
            m = 1 + int'($urandom % 12);
            d = dim(m, y) - int'($urandom % 3);
            n = 1 + int'($urandom % 70);
            load(y, m, d, 22 + int'($urandom % 2), 58 + int'($urandom % 2), 55 + int'($urandom % 5));
            ticks(4 * n); adv(n);
            check_time("R3 R4 R5 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule